// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block holds the starting address of a memory access and produces the four-beat burst address sequence that a synchronous memory works through. Either of two active-low address strobes can capture a full address. The controller-side strobe loads unconditionally. The processor-side strobe loads only when the active-low chip enable is also asserted. After a load, each clock edge with the active-low advance input asserted moves the burst to its next beat. With advance deasserted, the burst holds on its current beat.

Only the two least significant address bits are sequenced. A mode input, sampled while reset is held, selects the order of those two bits. In interleaved order the low bits are the start bits XOR the beat number. In linear order the low bits count up modulo four from the start bits. The upper address bits pass through unchanged for the whole burst. The block outputs the current address and the beat index. A memory array and data path use both.

Top module: `burst_addr_seq`

## Requirements
- R1: A clock edge with `ld_ctl_n` low loads `addr_i`, whatever the level of `ce_n`. After that edge `addr_o` equals the loaded address and `beat_o` is 0.
- R2: `ld_cpu_n` low loads `addr_i` only if `ce_n` is low at the same edge. With `ce_n` high it changes neither `addr_o` nor `beat_o`.
- R3: With no load, a clock edge with `adv_n` low increments `beat_o` by one. An edge with `adv_n` high leaves both `addr_o` and `beat_o` unchanged.
- R4: With interleaved order (`ilv_mode_i` = 1 at reset), `addr_o[1:0]` equals the start bits XOR `beat_o`. For example, start 01 gives 01, 00, 11, 10.
- R5: With linear order (`ilv_mode_i` = 0 at reset), `addr_o[1:0]` equals (start bits + `beat_o`) mod 4. For example, start 10 gives 10, 11, 00, 01.
- R6: An advance from beat 3 wraps to beat 0, which puts the start address back on `addr_o`.
- R7: A load in the same cycle as an advance takes priority: the new address is captured and `beat_o` returns to 0.
- R8: `ilv_mode_i` is sampled only while `rst_n` is low. A change of `ilv_mode_i` after reset has no effect on the order.
- R9: `addr_o[ADDR_W-1:2]` equals the loaded address's upper bits on every beat of the burst.
- R10: While `rst_n` is low, and after its release with no load, `addr_o` is 0 and `beat_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also samples the order mode |
| ilv_mode_i | input | 1 | Order select: 1 interleaved, 0 linear; static after reset |
| ld_ctl_n | input | 1 | Controller address strobe, active low |
| ld_cpu_n | input | 1 | Processor address strobe, active low, gated by `ce_n` |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr_i | input | ADDR_W | Address to load |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Current beat index, 0 to 3 |

## Verification
The assertions check the following on every cycle:
- the beat counter steps, holds or clears according to advance and load;
- a controller strobe always lands the presented address at beat 0;
- a cycle with no effective strobe and no advance leaves the outputs untouched;
- the latched order mode never changes outside reset.

Only the bench's scenarios can show the following:
- the actual interleaved and linear address orders from a given start;
- the wrap back to the start address;
- the pass-through of the upper bits;
- that a mode change after reset leaves a linear burst linear.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   // number of sequenced low address bits; four beats per burst
   localparam int BEAT_W = 2;

   typedef logic [BEAT_W-1:0] beat_t;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } order_e;
endpackage

// File: rtl/bas_strobe_decode.sv
module bas_strobe_decode (
   input  logic ld_ctl_n,
   input  logic ld_cpu_n,
   input  logic ce_n,
   output logic load_o
);
   // controller strobe is ungated; processor strobe needs chip enable
   logic ctl_hit;
   logic cpu_hit;

   always_comb begin
      ctl_hit = ~ld_ctl_n;
      cpu_hit = ~ld_cpu_n & ~ce_n;
      load_o  = ctl_hit | cpu_hit;
   end
endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
   import burst_seq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load_i,
   input  logic  adv_n,
   output beat_t cnt_o
);
   beat_t cnt_q;

   // load wins over advance; natural modulo-4 wrap
   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (load_i)  cnt_q <= '0;
      else if (!adv_n)  cnt_q <= cnt_q + beat_t'(1);
   end

   assign cnt_o = cnt_q;

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && adv_n) |=> (cnt_o == $past(cnt_o)))
      else $error("R3 beat moved without advance");

   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_n) |=> (cnt_o == beat_t'($past(cnt_o) + beat_t'(1))))
      else $error("R3 beat did not step by one");

   a_r7_load_clear: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_o == '0))
      else $error("R7 load did not clear beat");
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 18
) (
   input  logic [ADDR_W-1:0] base_i,
   input  beat_t             cnt_i,
   input  order_e            mode_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int UP_W = ADDR_W - BEAT_W;

   beat_t lo_ilv;
   beat_t lo_lin;
   beat_t lo_sel;

   always_comb begin
      lo_ilv = base_i[BEAT_W-1:0] ^ cnt_i;
      lo_lin = base_i[BEAT_W-1:0] + cnt_i;
      lo_sel = (mode_i == ORD_INTERLEAVE) ? lo_ilv : lo_lin;
   end

   generate
      if (UP_W > 0) begin : g_upper
         assign addr_o = {base_i[ADDR_W-1:BEAT_W], lo_sel};
      end else begin : g_low_only
         assign addr_o = lo_sel;
      end
   endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ilv_mode_i,
   input  logic              ld_ctl_n,
   input  logic              ld_cpu_n,
   input  logic              ce_n,
   input  logic              adv_n,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [1:0]        beat_o
);
   generate
      if (ADDR_W < BEAT_W + 1) begin : g_chk_width
         $error("burst_addr_seq: ADDR_W must exceed the sequenced bits");
      end
   endgenerate

   logic              load;
   logic [ADDR_W-1:0] base_q;
   order_e            mode_q;
   beat_t             cnt;

   bas_strobe_decode i_dec (
      .ld_ctl_n (ld_ctl_n),
      .ld_cpu_n (ld_cpu_n),
      .ce_n     (ce_n),
      .load_o   (load)
   );

   // mode captured only under reset, frozen afterwards
   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= ilv_mode_i ? ORD_INTERLEAVE : ORD_LINEAR;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     base_q <= '0;
      else if (load)  base_q <= addr_i;
   end

   bas_beat_ctr i_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .adv_n  (adv_n),
      .cnt_o  (cnt)
   );

   bas_order_map #(.ADDR_W(ADDR_W)) i_map (
      .base_i (base_q),
      .cnt_i  (cnt),
      .mode_i (mode_q),
      .addr_o (addr_o)
   );

   assign beat_o = cnt;

   a_r1_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_ctl_n |=> (addr_o == $past(addr_i) && beat_o == 2'd0))
      else $error("R1 controller strobe did not load");

   a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_ctl_n && (ld_cpu_n || ce_n) && adv_n) |=> ($stable(addr_o) && $stable(beat_o)))
      else $error("R2 outputs moved with no effective strobe");

   a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(mode_q))
      else $error("R8 order mode changed after reset");
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
   localparam int AW = 18;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ilv_mode_i;
   logic          ld_ctl_n, ld_cpu_n, ce_n, adv_n;
   logic [AW-1:0] addr_i;
   logic [AW-1:0] addr_o;
   logic [1:0]    beat_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
      .clk(clk), .rst_n(rst_n), .ilv_mode_i(ilv_mode_i),
      .ld_ctl_n(ld_ctl_n), .ld_cpu_n(ld_cpu_n), .ce_n(ce_n), .adv_n(adv_n),
      .addr_i(addr_i), .addr_o(addr_o), .beat_o(beat_o)
   );

   typedef struct packed {
      logic          ctl_n;
      logic          cpu_n;
      logic          ce_n;
      logic          adv_n;
      logic [AW-1:0] a_in;
      logic [AW-1:0] a_exp;
      logic [1:0]    b_exp;
      logic [3:0]    req;
   } vec_t;

   // interleaved order (mode=1 at reset); req holds the requirement number
   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b1, 1'b1, 1'b1, 18'h002A5, 18'h002A5, 2'd0, 4'd1},  // R1 load with ce_n high
      '{1'b1, 1'b1, 1'b1, 1'b0, 18'h3FFFF, 18'h002A4, 2'd1, 4'd4},  // R4 01^1
      '{1'b1, 1'b1, 1'b1, 1'b0, 18'h3FFFF, 18'h002A7, 2'd2, 4'd4},  // R4 01^2
      '{1'b1, 1'b1, 1'b1, 1'b0, 18'h3FFFF, 18'h002A6, 2'd3, 4'd4},  // R4 01^3
      '{1'b1, 1'b1, 1'b1, 1'b0, 18'h3FFFF, 18'h002A5, 2'd0, 4'd6},  // R6 wrap
      '{1'b1, 1'b1, 1'b1, 1'b0, 18'h00000, 18'h002A4, 2'd1, 4'd3},  // R3 step
      '{1'b1, 1'b1, 1'b1, 1'b1, 18'h00000, 18'h002A4, 2'd1, 4'd3},  // R3 hold
      '{1'b1, 1'b0, 1'b1, 1'b1, 18'h01234, 18'h002A4, 2'd1, 4'd2},  // R2 gated by ce_n
      '{1'b1, 1'b0, 1'b0, 1'b1, 18'h01234, 18'h01234, 2'd0, 4'd2},  // R2 load with ce_n low
      '{1'b0, 1'b1, 1'b1, 1'b0, 18'h3000B, 18'h3000B, 2'd0, 4'd7},  // R7 load beats advance
      '{1'b1, 1'b1, 1'b1, 1'b0, 18'h00000, 18'h3000A, 2'd1, 4'd9}   // R9 upper bits kept
   };

   task automatic check(input string req, input logic [AW-1:0] exp_a, input logic [1:0] exp_b);
      n_chk++;
      if (addr_o !== exp_a || beat_o !== exp_b) begin
         n_fail++;
         $display("FAIL %s: addr=%h beat=%0d, expected addr=%h beat=%0d",
                  req, addr_o, beat_o, exp_a, exp_b);
      end
   endtask

   task automatic idle();
      ld_ctl_n = 1'b1; ld_cpu_n = 1'b1; ce_n = 1'b1; adv_n = 1'b1;
      addr_i = '0;
   endtask

   task automatic step(input logic c, input logic p, input logic e, input logic a,
                       input logic [AW-1:0] ain);
      ld_ctl_n = c; ld_cpu_n = p; ce_n = e; adv_n = a; addr_i = ain;
      @(negedge clk);
   endtask

   task automatic do_reset(input logic mode);
      rst_n = 1'b0; ilv_mode_i = mode; idle();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; ilv_mode_i = 1'b1; idle();
      @(negedge clk);
      do_reset(1'b1);
      check("R10 in reset", '0, 2'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 after release", '0, 2'd0);

      // vector table, interleaved mode
      for (int i = 0; i < NV; i++) begin
         step(VECS[i].ctl_n, VECS[i].cpu_n, VECS[i].ce_n, VECS[i].adv_n, VECS[i].a_in);
         check($sformatf("R%0d vec %0d", VECS[i].req, i), VECS[i].a_exp, VECS[i].b_exp);
      end

      // linear order; mode pin flips after reset and must be ignored (R8)
      do_reset(1'b0);
      rst_n = 1'b1;
      ilv_mode_i = 1'b1;
      step(1'b0, 1'b1, 1'b1, 1'b1, 18'h0AAAA);
      check("R5 linear start", 18'h0AAAA, 2'd0);
      step(1'b1, 1'b1, 1'b1, 1'b0, '0);
      check("R5 R8 linear 10->11", 18'h0AAAB, 2'd1);
      step(1'b1, 1'b1, 1'b1, 1'b0, '0);
      check("R5 linear 11->00", 18'h0AAA8, 2'd2);
      step(1'b1, 1'b1, 1'b1, 1'b0, '0);
      check("R5 linear 00->01", 18'h0AAA9, 2'd3);
      step(1'b1, 1'b1, 1'b1, 1'b0, '0);
      check("R6 linear wrap", 18'h0AAAA, 2'd0);
      step(1'b1, 1'b1, 1'b1, 1'b1, 18'h3FFFF);
      check("R3 linear hold", 18'h0AAAA, 2'd0);

      // R1: controller strobe with processor strobe and chip enable also active
      step(1'b0, 1'b0, 1'b0, 1'b0, 18'h3FFFF);
      check("R1 simultaneous strobes", 18'h3FFFF, 2'd0);
      step(1'b1, 1'b1, 1'b1, 1'b0, '0);
      check("R5 R9 linear 11->00 top bits", 18'h3FFFC, 2'd1);

      idle();
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule